// File: doc/BRIEF.md
# I2C Master Register and FIFO Front-End

This block is the software-visible half of a byte-oriented I2C master. It holds the controller's configuration and status on a small 16-bit register bus: a clock divider, a word that carries both interrupt enables and the latched transfer events, a command word holding the target address and the start request, and a byte count. It also holds two byte FIFOs that sit between software and a separate bus engine. Software fills one FIFO with bytes to send and empties the other of bytes received. The bus engine, which drives the I2C pins, is not part of this block.

Software programs the divider and the length, and loads the transmit FIFO for a write. It then writes the command word with the start bit set. The block passes a one-cycle start pulse to the engine, together with the address, the direction, the length and the no-stop choice. The engine reports completion and NACKs as single-cycle pulses, takes bytes from the transmit FIFO and pushes received bytes. One interrupt line combines the enabled events with each FIFO's service request.

Top module: `i2c_regfront`

## Requirements
- R1: After reset, the divider at byte offset 0x00 reads 156. Offsets 0x02, 0x04, 0x06, 0x18 and 0x28 read 0, and `irq` is low.
- R2: The divider (0x00) and the length (0x06) read back the last value written. The length also drives `eng_len`. In the word at 0x02, bits 2:0 are read/write enables for complete, address NACK and data NACK.
- R3: In the word at 0x02, bits 8, 9 and 10 latch pulses on `eng_done`, `eng_anack` and `eng_dnack`. Writing 1 to one of these bits clears it, and writing 0 leaves it unchanged. An event that arrives in the same cycle as the clear leaves the bit set.
- R4: `irq` is high when a latched event in bits 10:8 has its enable set in bits 2:0, or when either FIFO service flag of R5 is high.
- R5: Bit 11 of 0x02 reads 1 when the transmit FIFO interrupt is enabled and the FIFO is not full. Bit 12 reads 1 when the receive FIFO interrupt is enabled and the FIFO holds at least one byte.
- R6: A write to 0x04 with bit 8 set and bit 13 clear raises `eng_start` for exactly one cycle, starting in the cycle after the write. `eng_addr` is then bits 7:1, `eng_read` is bit 0 (1 means read) and `eng_nostop` is bit 9. Offset 0x04 reads back bit 9 and bits 7:0, with bit 8 reading 0.
- R7: A write to 0x04 with bit 13 set raises `eng_abort` for one cycle, clears bits 10:8 of 0x02 and gives no start.
- R8: A write to 0x10 pushes the low data byte into the 16-byte transmit FIFO. The engine sees the FIFO in arrival order on `eng_tx_data` and `eng_tx_valid`, and each `eng_tx_pop` removes one byte. Bits 5:0 of 0x18 read the occupancy.
- R9: A write to 0x10 while the transmit FIFO holds 16 bytes is ignored: the occupancy stays 16 and the stored bytes do not change.
- R10: An `eng_rx_push` stores `eng_rx_data` in the 16-byte receive FIFO. A read of 0x20 returns the oldest byte and removes it. Bits 5:0 of 0x28 read the occupancy, and `eng_rx_full` is high at 16 bytes.
- R11: A read of 0x20 from an empty receive FIFO returns 0 and changes nothing. A push into a full receive FIFO is dropped.
- R12: In 0x18 and 0x28, bit 15 is a read/write interrupt enable for that FIFO. Writing bit 14 as 1 empties that FIFO, and bit 14 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe; pops the receive FIFO at 0x20 |
| reg_wdata | input | 16 | Write data; FIFO ports use bits 7:0 |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| eng_clkdiv | output | 16 | Clock divider value for the engine |
| eng_len | output | 16 | Byte count of the transfer |
| eng_addr | output | 7 | Target address |
| eng_read | output | 1 | Direction, 1 means read |
| eng_nostop | output | 1 | End the transfer without STOP |
| eng_start | output | 1 | One-cycle start request |
| eng_abort | output | 1 | One-cycle abort request |
| eng_done | input | 1 | Transfer complete pulse |
| eng_anack | input | 1 | Address NACK pulse |
| eng_dnack | input | 1 | Data NACK pulse |
| eng_tx_data | output | 8 | Oldest byte in the transmit FIFO |
| eng_tx_valid | output | 1 | Transmit FIFO is not empty |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_push | input | 1 | Store `eng_rx_data` |
| eng_rx_full | output | 1 | Receive FIFO holds 16 bytes |

## Verification
The assertions assume one bus access per cycle: `reg_wr` and `reg_rd` are never high together. They also assume that the engine's event, pop and push inputs are clean single-cycle pulses that change only when reset is inactive. Under these assumptions the occupancy bounds, the ignored full-FIFO write, the flush, the start and abort pulses, and the write-one-to-clear behaviour can be stated as simple next-cycle properties. The bench drives every input on the falling edge, one access at a time, and holds each engine pulse for exactly one cycle. It sweeps all 64 combinations of enables and events, and it fills and drains both FIFOs past their limits, so the assertions see the full-FIFO and empty-FIFO edges without the stimulus breaking those assumptions.

// File: rtl/i2c_regfront.sv
module i2c_regfront #(
  parameter int DEPTH      = 16,
  parameter int DIV_RESET  = 156
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic [15:0] eng_clkdiv,
  output logic [15:0] eng_len,
  output logic [6:0]  eng_addr,
  output logic        eng_read,
  output logic        eng_nostop,
  output logic        eng_start,
  output logic        eng_abort,
  input  logic        eng_done,
  input  logic        eng_anack,
  input  logic        eng_dnack,
  output logic [7:0]  eng_tx_data,
  output logic        eng_tx_valid,
  input  logic        eng_tx_pop,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_rx_push,
  output logic        eng_rx_full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  localparam logic [5:0] A_DIV  = 6'h00;
  localparam logic [5:0] A_CTL0 = 6'h02;
  localparam logic [5:0] A_CTL1 = 6'h04;
  localparam logic [5:0] A_LEN  = 6'h06;
  localparam logic [5:0] A_TXD  = 6'h10;
  localparam logic [5:0] A_TXS  = 6'h18;
  localparam logic [5:0] A_RXD  = 6'h20;
  localparam logic [5:0] A_RXS  = 6'h28;

  logic [15:0]   clkdiv_q, len_q;
  logic [2:0]    en_q, ev_q, ev_d;
  logic [6:0]    taddr_q;
  logic          rd_q, nostop_q, start_q, abort_q;
  logic          tx_ie_q, rx_ie_q;
  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_div  = reg_wr && reg_addr == A_DIV;
  wire wr_ctl0 = reg_wr && reg_addr == A_CTL0;
  wire wr_ctl1 = reg_wr && reg_addr == A_CTL1;
  wire wr_len  = reg_wr && reg_addr == A_LEN;
  wire wr_txs  = reg_wr && reg_addr == A_TXS;
  wire wr_rxs  = reg_wr && reg_addr == A_RXS;

  wire tx_push  = reg_wr && reg_addr == A_TXD && tx_cnt != FULL;
  wire tx_pop   = eng_tx_pop && tx_cnt != '0;
  wire tx_flush = wr_txs && reg_wdata[14];
  wire rx_push  = eng_rx_push && rx_cnt != FULL;
  wire rx_pop   = reg_rd && reg_addr == A_RXD && rx_cnt != '0;
  wire rx_flush = wr_rxs && reg_wdata[14];
  wire do_abort = wr_ctl1 && reg_wdata[13];

  wire tx_flag = tx_ie_q && tx_cnt != FULL;
  wire rx_flag = rx_ie_q && rx_cnt != '0;

  always_comb begin
    ev_d = ev_q;
    if (wr_ctl0)  ev_d = ev_d & ~reg_wdata[10:8];
    if (do_abort) ev_d = '0;
    ev_d = ev_d | {eng_dnack, eng_anack, eng_done};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkdiv_q <= 16'(DIV_RESET);
      len_q    <= '0;
      en_q     <= '0;
      ev_q     <= '0;
      taddr_q  <= '0;
      rd_q     <= 1'b0;
      nostop_q <= 1'b0;
      start_q  <= 1'b0;
      abort_q  <= 1'b0;
      tx_ie_q  <= 1'b0;
      rx_ie_q  <= 1'b0;
    end else begin
      ev_q    <= ev_d;
      start_q <= wr_ctl1 && reg_wdata[8] && !reg_wdata[13];
      abort_q <= do_abort;
      if (wr_div)  clkdiv_q <= reg_wdata;
      if (wr_len)  len_q    <= reg_wdata;
      if (wr_ctl0) en_q     <= reg_wdata[2:0];
      if (wr_ctl1 && !reg_wdata[13]) begin
        taddr_q  <= reg_wdata[7:1];
        rd_q     <= reg_wdata[0];
        nostop_q <= reg_wdata[9];
      end
      if (wr_txs) tx_ie_q <= reg_wdata[15];
      if (wr_rxs) rx_ie_q <= reg_wdata[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push && !tx_flush) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push && !rx_flush) rx_mem[rx_wp] <= eng_rx_data;
  end

  always_comb begin
    case (reg_addr)
      A_DIV:   reg_rdata = clkdiv_q;
      A_CTL0:  reg_rdata = {3'b000, rx_flag, tx_flag, ev_q, 5'b00000, en_q};
      A_CTL1:  reg_rdata = {6'b000000, nostop_q, 1'b0, taddr_q, rd_q};
      A_LEN:   reg_rdata = len_q;
      A_TXS:   reg_rdata = {tx_ie_q, 9'b0, 6'(tx_cnt)};
      A_RXD:   reg_rdata = {8'h00, (rx_cnt != '0) ? rx_mem[rx_rp] : 8'h00};
      A_RXS:   reg_rdata = {rx_ie_q, 9'b0, 6'(rx_cnt)};
      default: reg_rdata = '0;
    endcase
  end

  assign irq          = |(ev_q & en_q) | tx_flag | rx_flag;
  assign eng_clkdiv   = clkdiv_q;
  assign eng_len      = len_q;
  assign eng_addr     = taddr_q;
  assign eng_read     = rd_q;
  assign eng_nostop   = nostop_q;
  assign eng_start    = start_q;
  assign eng_abort    = abort_q;
  assign eng_tx_data  = (tx_cnt != '0) ? tx_mem[tx_rp] : 8'h00;
  assign eng_tx_valid = tx_cnt != '0;
  assign eng_rx_full  = rx_cnt == FULL;
endmodule

// File: rtl/i2c_regfront_chk.sv
module i2c_regfront_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [15:0]   reg_wdata,
  input logic          eng_done,
  input logic          eng_anack,
  input logic          eng_dnack,
  input logic          eng_tx_pop,
  input logic          eng_rx_push,
  input logic          eng_start,
  input logic          eng_abort,
  input logic [2:0]    ev_q,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  p_tx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);

  p_tx_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 6'h10 && tx_cnt == FULL && !eng_tx_pop |=> tx_cnt == FULL);

  p_rx_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 6'h20 && rx_cnt == '0 && !eng_rx_push |=> rx_cnt == '0);

  p_rx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL);

  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 6'h18 && reg_wdata[14] |=> tx_cnt == '0);

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 6'h04 && reg_wdata[8] && !reg_wdata[13] |=> eng_start);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 6'h04 && reg_wdata[13] && !(eng_done || eng_anack || eng_dnack)
    |=> eng_abort && !eng_start && ev_q == 3'b000);

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 6'h02 && reg_wdata[8] && !eng_done |=> !ev_q[0]);
endmodule

bind i2c_regfront i2c_regfront_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .eng_done(eng_done), .eng_anack(eng_anack),
  .eng_dnack(eng_dnack), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
  .eng_start(eng_start), .eng_abort(eng_abort), .ev_q(ev_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/i2c_regfront_bench.sv
module i2c_regfront_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [5:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq;
  logic [15:0] eng_clkdiv, eng_len;
  logic [6:0] eng_addr;
  logic eng_read, eng_nostop, eng_start, eng_abort;
  logic eng_done = 0, eng_anack = 0, eng_dnack = 0;
  logic [7:0] eng_tx_data;
  logic eng_tx_valid, eng_tx_pop = 0;
  logic [7:0] eng_rx_data = '0;
  logic eng_rx_push = 0, eng_rx_full;

  int checks = 0, errors = 0;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regfront u_i2c_regfront (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse_ev(logic [2:0] e);
    {eng_dnack, eng_anack, eng_done} = e;
    @(negedge clk); {eng_dnack, eng_anack, eng_done} = 3'b000;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(6'h00, v); chk("R1 div", v, 16'd156);
    rd(6'h02, v); chk("R1 ctl0", v, 0);
    rd(6'h04, v); chk("R1 ctl1", v, 0);
    rd(6'h06, v); chk("R1 len", v, 0);
    rd(6'h18, v); chk("R1 txs", v, 0);
    rd(6'h28, v); chk("R1 rxs", v, 0);
    chk("R1 irq", irq, 0);

    // R2 read/write registers
    wr(6'h00, 16'h1234); rd(6'h00, v); chk("R2 div", v, 16'h1234);
    chk("R2 eng_clkdiv", eng_clkdiv, 16'h1234);
    wr(6'h06, 16'h00AB); rd(6'h06, v); chk("R2 len", v, 16'h00AB);
    chk("R2 eng_len", eng_len, 16'h00AB);

    // R6 start request
    wr(6'h04, 16'h0300 | (16'h5A << 1) | 16'h1);
    chk("R6 start", eng_start, 1);
    chk("R6 addr", eng_addr, 16'h5A);
    chk("R6 read", eng_read, 1);
    chk("R6 nostop", eng_nostop, 1);
    @(negedge clk); chk("R6 start one cycle", eng_start, 0);
    rd(6'h04, v); chk("R6 readback", v, 16'h02B5);
    wr(6'h04, 16'h0100 | (16'h21 << 1));
    chk("R6 write start", eng_start, 1);
    chk("R6 write dir", eng_read, 0);
    chk("R6 stop", eng_nostop, 0);

    // R2 R3 R4 sweep of enables against events
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 8; ev++) begin
        wr(6'h04, 16'h2000);
        wr(6'h02, 16'(en));
        pulse_ev(3'(ev));
        rd(6'h02, v); chk("R2 R3 ctl0", v, 16'((ev << 8) | en));
        chk("R4 irq", irq, ((en & ev) != 0) ? 1 : 0);
      end
    end

    // R3 write-one-to-clear, write-zero keeps
    wr(6'h04, 16'h2000); wr(6'h02, 16'h0000);
    pulse_ev(3'b111);
    wr(6'h02, 16'h0200); rd(6'h02, v); chk("R3 w1c", v, 16'h0500);
    // R3 set wins over clear
    reg_addr = 6'h02; reg_wdata = 16'h0100; reg_wr = 1; eng_done = 1;
    @(negedge clk); reg_wr = 0; eng_done = 0;
    rd(6'h02, v); chk("R3 set wins", v, 16'h0500);

    // R7 soft reset
    wr(6'h04, 16'h2100);
    chk("R7 abort", eng_abort, 1);
    chk("R7 no start", eng_start, 0);
    rd(6'h02, v); chk("R7 cleared", v, 16'h0000);
    chk("R7 abort one cycle", eng_abort, 0);

    // R5 R8 R9 transmit fill
    wr(6'h18, 16'h8000);
    chk("R4 R5 tx irq", irq, 1);
    for (int i = 0; i < 18; i++) begin
      int exp_cnt;
      wr(6'h10, 16'hAB00 | 16'((i * 7 + 3) & 8'hFF));
      exp_cnt = (i + 1 > 16) ? 16 : i + 1;
      rd(6'h18, v); chk("R8 R9 tx count", v, 16'h8000 | 16'(exp_cnt));
      rd(6'h02, v); chk("R5 tx flag", v[11], (exp_cnt < 16) ? 1 : 0);
      chk("R4 irq tx", irq, (exp_cnt < 16) ? 1 : 0);
    end
    // R8 R9 drain in order; bytes written while full must not appear
    for (int i = 0; i < 16; i++) begin
      chk("R8 tx valid", eng_tx_valid, 1);
      chk("R8 R9 tx data", eng_tx_data, 16'((i * 7 + 3) & 8'hFF));
      eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
      rd(6'h18, v); chk("R8 drain count", v, 16'h8000 | 16'(15 - i));
    end
    chk("R8 empty", eng_tx_valid, 0);
    eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
    rd(6'h18, v); chk("R8 pop empty", v, 16'h8000);

    // R12 flush
    for (int i = 0; i < 5; i++) wr(6'h10, 16'(i));
    rd(6'h18, v); chk("R12 pre flush", v, 16'h8005);
    wr(6'h18, 16'h4000);
    rd(6'h18, v); chk("R12 flush", v, 16'h0000);
    chk("R12 irq off", irq, 0);

    // R10 R11 receive
    rd(6'h20, v); chk("R11 empty read", v, 16'h0000);
    rd(6'h28, v); chk("R11 empty count", v, 16'h0000);
    wr(6'h28, 16'h8000);
    rd(6'h02, v); chk("R5 rx flag empty", v[12], 0);
    for (int i = 0; i < 18; i++) begin
      int exp_cnt;
      eng_rx_data = 8'(i ^ 8'hA5); eng_rx_push = 1;
      @(negedge clk); eng_rx_push = 0;
      exp_cnt = (i + 1 > 16) ? 16 : i + 1;
      rd(6'h28, v); chk("R10 R11 rx count", v, 16'h8000 | 16'(exp_cnt));
      chk("R10 rx full", eng_rx_full, (exp_cnt == 16) ? 1 : 0);
    end
    rd(6'h02, v); chk("R5 rx flag", v[12], 1);
    chk("R4 irq rx", irq, 1);
    for (int i = 0; i < 16; i++) begin
      rd(6'h20, v); chk("R10 R11 rx data", v, 16'(i ^ 8'hA5));
    end
    rd(6'h28, v); chk("R10 drained", v, 16'h8000);
    rd(6'h20, v); chk("R11 read empty again", v, 16'h0000);
    rd(6'h28, v); chk("R11 count stays", v, 16'h8000);
    chk("R4 irq idle", irq, 0);

    // R12 receive flush
    for (int i = 0; i < 3; i++) begin
      eng_rx_data = 8'(i); eng_rx_push = 1; @(negedge clk); eng_rx_push = 0;
    end
    wr(6'h28, 16'hC000);
    rd(6'h28, v); chk("R12 rx flush", v, 16'h8000);

    finish_run();
  end
endmodule